// File: doc/BRIEF.md
# PROM and I/O Bus Cycle Controller

This block runs single external bus cycles for two address areas: a boot-PROM area and an I/O area. A 32-bit configuration register sets the wait states, data width, ready handling, protection and exception handling for each area. An internal requester presents one read or write at a time with a 32-bit address and data. The block drives the external address, data, area chip-selects and the output and write enables. It finishes with either a done pulse, carrying read data, or an error pulse.

Each access has a number of wait states. PROM wait states come in steps of two, and I/O wait states come in steps of one. A ready-enabled area also holds the cycle after its wait states until the active-low ready input is seen. Ready can be sampled directly on the clock, or through a two-flop synchronizer when it comes from an unclocked source. An area set to 8-bit width turns one 32-bit access into four byte cycles, most significant byte first. An enabled bus-exception input ends the access with an error.

Top module: `prom_io_bus_ctrl`

## Requirements
- R1: After reset the configuration reads 0x0000000F: PROM read wait field 15, every other field 0, so the PROM is 8-bit wide. All strobes are high and done and error are low. A PROM read in this state makes four byte cycles of 31 clocks each.
- R2: A configuration write stores bits 21:0 and reads back with bits 31:22 at zero. The layout is: [3:0] PROM read wait field, [7:4] PROM write wait field, [9:8] PROM width, [10] PROM write enable, [11] PROM ready enable, [15:12] I/O wait field, [17:16] I/O width, [18] I/O enable, [19] I/O ready enable, [20] asynchronous ready, [21] exception enable.
- R3: A PROM read with read wait field n holds the chip-select and output enable low for 1+2n clocks. Done then pulses for one clock, with the captured read data on the read-data output.
- R4: A PROM write with write wait field n holds the chip-select and write enable low for 1+2n clocks, with the write data on the bus.
- R5: An I/O access with I/O wait field n holds the I/O chip-select and its enable low for 1+n clocks.
- R6: A PROM write with the PROM write enable clear drives no strobe and pulses error in the clock after the request. PROM reads are unaffected.
- R7: Any I/O access with the I/O enable clear drives no strobe and pulses error in the clock after the request.
- R8: With the area's ready enable set and asynchronous mode clear, the cycle ends at the first clock edge, after the wait states, that samples the ready input low. An area whose ready enable is clear ignores the ready input.
- R9: In asynchronous mode, ready passes through two flops before use, so the cycle ends two clocks later than in direct mode for the same ready timing.
- R10: With the exception enable set, a clock edge that samples the exception input low during an access ends it with an error pulse in the next clock and releases all strobes. With the enable clear, the input has no effect.
- R11: Width code 00 selects 8-bit and code 10 selects 32-bit. In 8-bit mode an access is four byte cycles at word-aligned address +0..+3, and each byte cycle takes the full wait-state count. Byte lane [7:0] carries write bits 31:24 first, and read bytes are packed most significant first.
- R12: Address bits 31:28 select the area: 0 is PROM and 2 is I/O. Any other value returns an error in the clock after the request, with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write value |
| cfg_rdata_o | output | 32 | Current configuration |
| req_i | input | 1 | Request pulse, sampled while idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Request address |
| req_wdata_i | input | 32 | Request write data |
| done_o | output | 1 | One-clock normal completion |
| err_o | output | 1 | One-clock error completion |
| rdata_o | output | 32 | Read data, valid with done_o |
| bus_addr_o | output | 32 | External address |
| bus_data_o | output | 32 | External write data |
| bus_data_i | input | 32 | External read data |
| prom_cs_no | output | 1 | PROM chip-select, active low |
| io_cs_no | output | 1 | I/O chip-select, active low |
| oe_no | output | 1 | Output enable for reads, active low |
| we_no | output | 1 | Write enable, active low |
| brdy_ni | input | 1 | Bus ready, active low |
| bexc_ni | input | 1 | Bus exception, active low |

## Verification
A response is due a fixed number of clocks after the edge that accepts the request. Blocked or unmapped requests respond at once. A normal access responds after one plus its wait states for each beat, and four beats in 8-bit mode. Ready adds clocks up to one past the ready edge in direct mode and three in synchronized mode, and an exception ends the access one clock after it is sampled. The driver pushes this latency, together with the expected area, strobe length and data, into a queue before it raises the request. A monitor sampling at falling edges counts strobe clocks and, on each response, compares the elapsed clocks with that exact figure.

// File: rtl/prom_io_pkg.sv
package prom_io_pkg;

  typedef struct packed {
    logic [9:0] rsvd;
    logic       bexc_en;
    logic       async_rdy;
    logic       io_rdy_en;
    logic       io_en;
    logic [1:0] io_width;
    logic [3:0] io_ws;
    logic       prom_rdy_en;
    logic       prom_wr_en;
    logic [1:0] prom_width;
    logic [3:0] prom_wr_ws;
    logic [3:0] prom_rd_ws;
  } cfg_t;

  localparam logic [1:0]  WIDTH_8   = 2'b00;
  localparam logic [31:0] CFG_RST   = 32'h0000_000F;
  localparam logic [31:0] CFG_WMASK = 32'h003F_FFFF;

  typedef enum logic {ST_IDLE, ST_ACT} seq_st_e;

endpackage

// File: rtl/prom_io_cfg_reg.sv
module prom_io_cfg_reg
  import prom_io_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output cfg_t        cfg_o
);

  logic [31:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RST;
    else if (we_i) cfg_q <= wdata_i & CFG_WMASK;
  end

  assign cfg_o = cfg_t'(cfg_q);

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/prom_io_rdy_sync.sv
module prom_io_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brdy_ni,
  input  logic async_i,
  output logic rdy_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], ~brdy_ni};
  end

  // direct sampling when the source is clocked, synchronized otherwise
  assign rdy_o = async_i ? sync_q[STAGES-1] : ~brdy_ni;

  generate
    if (STAGES == 2) begin : g_chk2
      AST_SYNC_AGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (async_i && rdy_o) |-> $past(!brdy_ni, 2)); // R9
    end
  endgenerate

endmodule

// File: rtl/prom_io_seq.sv
module prom_io_seq
  import prom_io_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 32,
  parameter int              AREA_W    = 4,
  parameter logic [AREA_W-1:0] PROM_AREA = AREA_W'(0),
  parameter logic [AREA_W-1:0] IO_AREA   = AREA_W'(2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cfg_t              cfg_i,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              rdy_i,
  input  logic              bexc_ni,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              prom_cs_no,
  output logic              io_cs_no,
  output logic              oe_no,
  output logic              we_no
);

  localparam int BEATS  = DATA_W / 8;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int WS_W   = 5;

  seq_st_e           st_q;
  logic              prom_q, we_q, narrow_q, rdy_need_q, bexc_en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [BEAT_W-1:0] beat_q;
  logic [WS_W-1:0]   cnt_q, ws_q;
  logic              done_q, err_q;

  // request decode
  logic [AREA_W-1:0] area;
  logic              hit_prom, hit_io, blocked, narrow_sel, rdy_sel;
  logic [WS_W-1:0]   ws_sel;

  always_comb begin
    area     = req_addr_i[ADDR_W-1 -: AREA_W];
    hit_prom = (area == PROM_AREA);
    hit_io   = (area == IO_AREA);
    blocked  = !(hit_prom || hit_io)
             || (hit_prom && req_we_i && !cfg_i.prom_wr_en)
             || (hit_io && !cfg_i.io_en);
    if (hit_prom) begin
      ws_sel     = req_we_i ? {cfg_i.prom_wr_ws, 1'b0} : {cfg_i.prom_rd_ws, 1'b0};
      narrow_sel = (cfg_i.prom_width == WIDTH_8);
      rdy_sel    = cfg_i.prom_rdy_en;
    end else begin
      ws_sel     = {1'b0, cfg_i.io_ws};
      narrow_sel = (cfg_i.io_width == WIDTH_8);
      rdy_sel    = cfg_i.io_rdy_en;
    end
  end

  logic act, abort, beat_end, last_beat;
  assign act       = (st_q == ST_ACT);
  assign abort     = bexc_en_q && !bexc_ni;
  assign beat_end  = (cnt_q == '0) && (!rdy_need_q || rdy_i);
  assign last_beat = !narrow_q || (beat_q == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      prom_q     <= 1'b0;
      we_q       <= 1'b0;
      narrow_q   <= 1'b0;
      rdy_need_q <= 1'b0;
      bexc_en_q  <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      beat_q     <= '0;
      cnt_q      <= '0;
      ws_q       <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            if (blocked) begin
              err_q <= 1'b1;
            end else begin
              st_q       <= ST_ACT;
              prom_q     <= hit_prom;
              we_q       <= req_we_i;
              addr_q     <= req_addr_i;
              wdata_q    <= req_wdata_i;
              ws_q       <= ws_sel;
              cnt_q      <= ws_sel;
              narrow_q   <= narrow_sel;
              rdy_need_q <= rdy_sel;
              bexc_en_q  <= cfg_i.bexc_en;
              beat_q     <= '0;
            end
          end
        end
        ST_ACT: begin
          if (abort) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (beat_end) begin
            if (narrow_q) rdata_q <= {rdata_q[DATA_W-9:0], bus_data_i[7:0]};
            else          rdata_q <= bus_data_i;
            if (last_beat) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              beat_q <= beat_q + 1'b1;
              cnt_q  <= ws_q;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // external side
  logic [DATA_W-1:0] wshift;
  assign wshift     = wdata_q << {beat_q, 3'b000};
  assign bus_addr_o = narrow_q ? {addr_q[ADDR_W-1:BEAT_W], beat_q} : addr_q;
  assign bus_data_o = narrow_q ? {{(DATA_W-8){1'b0}}, wshift[DATA_W-1 -: 8]} : wdata_q;
  assign prom_cs_no = !(act && prom_q);
  assign io_cs_no   = !(act && !prom_q);
  assign oe_no      = !(act && !we_q);
  assign we_no      = !(act && we_q);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign rdata_o    = rdata_q;

  logic unused_cfg;
  assign unused_cfg = ^{cfg_i.rsvd, cfg_i.async_rdy};

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && cnt_q != '0 && !abort) |=> (act && !done_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_BLOCK_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act && req_i && blocked) |=> (err_o && prom_cs_no && io_cs_no)); // R6
  AST_PROM_WR_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && !prom_cs_no) |-> cfg_i.prom_wr_en); // R6
  AST_IO_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_cs_no |-> cfg_i.io_en); // R7
  AST_RDY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && cnt_q == '0 && rdy_need_q && !rdy_i && !abort) |=> (act && !done_o)); // R8
  AST_BEXC_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && abort) |=> (err_o && !done_o && prom_cs_no && io_cs_no)); // R10

endmodule

// File: rtl/prom_io_bus_ctrl.sv
module prom_io_bus_ctrl
  import prom_io_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter int                AREA_W      = 4,
  parameter logic [AREA_W-1:0] PROM_AREA   = AREA_W'(0),
  parameter logic [AREA_W-1:0] IO_AREA     = AREA_W'(2),
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              prom_cs_no,
  output logic              io_cs_no,
  output logic              oe_no,
  output logic              we_no,
  input  logic              brdy_ni,
  input  logic              bexc_ni
);

  cfg_t cfg;
  logic rdy;

  prom_io_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  assign cfg_rdata_o = cfg;

  prom_io_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .brdy_ni (brdy_ni),
    .async_i (cfg.async_rdy),
    .rdy_o   (rdy)
  );

  prom_io_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .AREA_W    (AREA_W),
    .PROM_AREA (PROM_AREA),
    .IO_AREA   (IO_AREA)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg),
    .req_i       (req_i),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rdy_i       (rdy),
    .bexc_ni     (bexc_ni),
    .bus_data_i  (bus_data_i),
    .done_o      (done_o),
    .err_o       (err_o),
    .rdata_o     (rdata_o),
    .bus_addr_o  (bus_addr_o),
    .bus_data_o  (bus_data_o),
    .prom_cs_no  (prom_cs_no),
    .io_cs_no    (io_cs_no),
    .oe_no       (oe_no),
    .we_no       (we_no)
  );

endmodule

// File: tb/sim_prom_io_bus_ctrl.sv
`timescale 1ns/1ps
module sim_prom_io_bus_ctrl;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        req_i = 1'b0, req_we_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic        done_o, err_o;
  logic [31:0] rdata_o, bus_addr_o, bus_data_o, bus_data_i;
  logic        prom_cs_no, io_cs_no, oe_no, we_no;
  logic        brdy_ni = 1'b1, bexc_ni = 1'b1;

  always #2.5 clk_i = ~clk_i;

  prom_io_bus_ctrl u0 (.*);

  // external device model: data is a function of address
  logic [7:0] ba;
  assign ba = bus_addr_o[7:0];
  assign bus_data_i = {ba ^ 8'h11, ba ^ 8'h22, ba ^ 8'h33, ba ^ 8'h44};

  function automatic logic [31:0] m32(input logic [31:0] a);
    return {a[7:0] ^ 8'h11, a[7:0] ^ 8'h22, a[7:0] ^ 8'h33, a[7:0] ^ 8'h44};
  endfunction
  function automatic logic [31:0] m8(input logic [31:0] a);
    logic [7:0] b;
    b = {a[7:2], 2'b00};
    return {b ^ 8'h44, (b + 8'd1) ^ 8'h44, (b + 8'd2) ^ 8'h44, (b + 8'd3) ^ 8'h44};
  endfunction
  function automatic logic [31:0] mk_cfg(
    input logic [3:0] prd, input logic [3:0] pwr, input logic [1:0] pwid,
    input logic pwen, input logic prdy, input logic [3:0] iws, input logic [1:0] iwid,
    input logic ioen, input logic iordy, input logic asy, input logic bx);
    return {10'b0, bx, asy, iordy, ioen, iwid, iws, prdy, pwen, pwid, pwr, prd};
  endfunction

  typedef struct {
    bit          is_err;
    bit          chk_rd;
    logic [31:0] rd;
    int          lat;
    int          area;
    int          issue;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_tests = 0, n_fail = 0;
  int   cyc = 0;
  int   strb_cnt = 0;
  bit   prom_seen = 0, io_seen = 0;
  logic [7:0]  wlog [4];
  logic [31:0] wfull;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!oe_no || !we_no) strb_cnt++;
      if (!prom_cs_no) prom_seen = 1;
      if (!io_cs_no)   io_seen = 1;
      if (!we_no) begin
        wlog[bus_addr_o[1:0]] = bus_data_o[7:0];
        wfull = bus_data_o;
      end
      if (done_o || err_o) begin
        if (sb.size() == 0) begin
          chk(0, "R3", "unexpected response", {31'b0, done_o}, 32'h0);
        end else begin
          exp_t e;
          int   ar;
          e = sb.pop_front();
          ar = prom_seen ? (io_seen ? 3 : 1) : (io_seen ? 2 : 0);
          chk(err_o == e.is_err && done_o == !e.is_err, e.tag, "error flag",
              {31'b0, err_o}, {31'b0, e.is_err});
          chk(cyc - e.issue == e.lat, e.tag, "latency", cyc - e.issue, e.lat);
          chk(strb_cnt == ((e.area == 0) ? 0 : e.lat), e.tag, "strobe clocks",
              strb_cnt, (e.area == 0) ? 0 : e.lat);
          chk(ar == e.area, e.tag, "area select", ar, e.area);
          if (e.chk_rd) chk(rdata_o == e.rd, e.tag, "read data", rdata_o, e.rd);
        end
        strb_cnt = 0;
        prom_seen = 0;
        io_seen = 0;
      end
    end
  end

  task automatic do_req(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        input bit e_err, input bit e_chk, input logic [31:0] e_rd,
                        input int e_lat, input int e_area, input int rdy_k,
                        input int bexc_k, input string tag);
    exp_t e;
    int   k;
    @(negedge clk_i);
    e.is_err = e_err; e.chk_rd = e_chk; e.rd = e_rd; e.lat = e_lat;
    e.area = e_area; e.issue = cyc + 1; e.tag = tag;
    sb.push_back(e);
    req_i = 1'b1; req_we_i = we; req_addr_i = addr; req_wdata_i = wd;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    k = 0;
    while (sb.size() != 0) begin
      if (k == rdy_k)  brdy_ni = 1'b0;
      if (k == bexc_k) bexc_ni = 1'b0;
      k++;
      @(negedge clk_i);
    end
    brdy_ni = 1'b1;
    bexc_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic set_cfg(input logic [31:0] v, input string tag);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk(cfg_rdata_o == (v & 32'h003F_FFFF), tag, "cfg readback", cfg_rdata_o, v & 32'h003F_FFFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(cfg_rdata_o == 32'h0000_000F, "R1", "reset cfg", cfg_rdata_o, 32'h0000_000F);
    chk({prom_cs_no, io_cs_no, oe_no, we_no} == 4'hF, "R1", "strobes idle",
        {28'b0, prom_cs_no, io_cs_no, oe_no, we_no}, 32'hF);
    chk({done_o, err_o} == 2'b00, "R1", "responses idle", {30'b0, done_o, err_o}, 0);
    // R1 default PROM: 8-bit, 30 waits per byte
    do_req(0, 32'h0000_0020, 0, 0, 1, m8(32'h20), 124, 1, -1, -1, "R1");

    // R2 mask
    set_cfg(32'hFFFF_FFFF, "R2");
    set_cfg(mk_cfg(4'd2, 4'd1, 2'b10, 1, 0, 4'd3, 2'b10, 1, 0, 0, 0), "R2");

    do_req(0, 32'h0000_0104, 0, 0, 1, m32(32'h104), 5, 1, -1, -1, "R3");
    do_req(1, 32'h0000_0200, 32'hDEAD_BEEF, 0, 0, 0, 3, 1, -1, -1, "R4");
    chk(wfull == 32'hDEAD_BEEF, "R4", "write data", wfull, 32'hDEAD_BEEF);
    do_req(0, 32'h2000_0008, 0, 0, 1, m32(32'h8), 4, 2, -1, -1, "R5");
    do_req(1, 32'h2000_000C, 32'h1234_5678, 0, 0, 0, 4, 2, -1, -1, "R5");
    chk(wfull == 32'h1234_5678, "R5", "io write data", wfull, 32'h1234_5678);

    // R6 PROM write protect
    set_cfg(mk_cfg(4'd2, 4'd1, 2'b10, 0, 0, 4'd3, 2'b10, 1, 0, 0, 0), "R6");
    do_req(1, 32'h0000_0300, 32'h5555_AAAA, 1, 0, 0, 0, 0, -1, -1, "R6");
    do_req(0, 32'h0000_0104, 0, 0, 1, m32(32'h104), 5, 1, -1, -1, "R6");

    // R7 I/O protect
    set_cfg(mk_cfg(4'd2, 4'd1, 2'b10, 1, 0, 4'd3, 2'b10, 0, 0, 0, 0), "R7");
    do_req(0, 32'h2000_0008, 0, 1, 0, 0, 0, 0, -1, -1, "R7");
    do_req(1, 32'h2000_0008, 32'h1, 1, 0, 0, 0, 0, -1, -1, "R7");

    // R12 unmapped area
    do_req(0, 32'h4000_0000, 0, 1, 0, 0, 0, 0, -1, -1, "R12");

    // R8 direct ready on PROM only
    set_cfg(mk_cfg(4'd2, 4'd1, 2'b10, 1, 1, 4'd3, 2'b10, 1, 0, 0, 0), "R8");
    do_req(0, 32'h0000_0104, 0, 0, 1, m32(32'h104), 9, 1, 8, -1, "R8");
    do_req(0, 32'h0000_0108, 0, 0, 1, m32(32'h108), 5, 1, 0, -1, "R8");
    do_req(0, 32'h2000_0010, 0, 0, 1, m32(32'h10), 4, 2, -1, -1, "R8");

    // R9 synchronized ready
    set_cfg(mk_cfg(4'd2, 4'd1, 2'b10, 1, 1, 4'd3, 2'b10, 1, 0, 1, 0), "R9");
    do_req(0, 32'h0000_0104, 0, 0, 1, m32(32'h104), 11, 1, 8, -1, "R9");
    do_req(0, 32'h0000_010C, 0, 0, 1, m32(32'h10C), 5, 1, 0, -1, "R9");

    // R10 exception abort and ignore
    set_cfg(mk_cfg(4'd15, 4'd1, 2'b10, 1, 0, 4'd3, 2'b10, 1, 0, 0, 1), "R10");
    do_req(0, 32'h0000_0104, 0, 1, 0, 0, 6, 1, -1, 5, "R10");
    set_cfg(mk_cfg(4'd15, 4'd1, 2'b10, 1, 0, 4'd3, 2'b10, 1, 0, 0, 0), "R10");
    do_req(0, 32'h0000_0104, 0, 0, 1, m32(32'h104), 31, 1, -1, 5, "R10");

    // R11 8-bit mode
    set_cfg(mk_cfg(4'd1, 4'd1, 2'b00, 1, 0, 4'd1, 2'b00, 1, 0, 0, 0), "R11");
    do_req(0, 32'h0000_0040, 0, 0, 1, m8(32'h40), 12, 1, -1, -1, "R11");
    do_req(1, 32'h2000_0010, 32'hA1B2_C3D4, 0, 0, 0, 8, 2, -1, -1, "R11");
    chk({wlog[0], wlog[1], wlog[2], wlog[3]} == 32'hA1B2_C3D4, "R11", "byte order",
        {wlog[0], wlog[1], wlog[2], wlog[3]}, 32'hA1B2_C3D4);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule